// File: doc/BRIEF.md
# Stack-Based Interrupt Entry and Return Sequencer

This controller sits next to a simple processor core and carries out interrupt entry as one indivisible hardware sequence. At an instruction boundary it checks the interrupt request line together with the enable bit of the core's status word. When both are active, it holds the core stalled and stores two words on a downward-growing stack in memory: first the return PC, then the status word. In the same cycle as the second store, it tells the core to load its PC from a programmable handler-address register and to load a status word whose enable bit is cleared.

A return request reverses this. The sequencer reads the status word back from the stack, then the PC, and the stack pointer climbs back to where it was. The restored status brings the enable bit back to its saved value. The stack pointer belongs to the sequencer and counts in words. Memory has one port with one access per cycle, and read data is combinational: it is valid in the same cycle as the read request.

Top module: `irq_stack_seq`

## Requirements
- R1: An entry starts only when `insn_boundary`, `irq_req` and the enable bit `core_status[IE_BIT]` are all high in the same cycle. In any other case there is no stall and no memory access.
- R2: In the cycle after an entry is accepted, the sequencer writes `core_pc_next`, as sampled at acceptance, to address SP-1. The stack pointer then becomes SP-1.
- R3: In the next cycle it writes the sampled `core_status` to the new SP-1. The stack pointer decrements again.
- R4: In that same second-write cycle, `pc_load` is high with `pc_load_val` equal to the handler register. `status_load` is also high, with `status_load_val` equal to the saved status except that bit IE_BIT is 0.
- R5: `stall` is high in the accepting cycle and in every cycle of a push or pop sequence, and low again in the cycle after the last step. There is never a cycle between steps in which the core could run.
- R6: The handler register resets to `HVEC_RESET`. It takes `hvec_wdata` on a clock edge where `hvec_we` is high.
- R7: When `insn_boundary` and `ret_req` are high together, the sequencer reads at SP and presents the read word on `status_load_val` with `status_load` high. In the next cycle it reads at SP+1 and presents that word on `pc_load_val` with `pc_load` high. The stack pointer ends two words higher.
- R8: While a push or pop sequence is under way, `irq_req` and `ret_req` are ignored and produce no extra memory access.
- R9: If an entry and a return are both requested in the same cycle, the return is taken.
- R10: After reset the sequencer is idle with `stall`, `mem_req`, `pc_load` and `status_load` low, and the stack pointer equals `STACK_TOP`. The first push then goes to `STACK_TOP`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_boundary | input | 1 | Core is between instructions |
| irq_req | input | 1 | Interrupt request line |
| ret_req | input | 1 | Return-from-interrupt request |
| core_pc_next | input | DATA_W | Address of the next instruction |
| core_status | input | DATA_W | Core status word |
| hvec_we | input | 1 | Handler register write strobe |
| hvec_wdata | input | DATA_W | Handler register write data |
| stall | output | 1 | Holds the core |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, same cycle |
| pc_load | output | 1 | Core must load its PC |
| pc_load_val | output | DATA_W | New PC value |
| status_load | output | 1 | Core must load its status |
| status_load_val | output | DATA_W | New status value |

## Verification
The assertions check the following on every cycle:
- an entry sequence begins only after a cycle in which the request, the enable bit and the boundary were all present;
- the status push always follows the PC push;
- a handler jump always comes with a cleared enable bit;
- every memory access happens under stall;
- the second pop address is one word above the first;
- no new sequence begins straight out of a busy state.

Only the bench scenarios can show that the stored data and addresses match what was sampled and that the stack pointer returns exactly to its start after nested entries and returns. They also show the return-over-entry priority and the handler register value in use before and after a write.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_PUSH_PC = 3'd1,
    S_PUSH_ST = 3'd2,
    S_POP_ST  = 3'd3,
    S_POP_PC  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_boundary,
  input  logic              irq_req,
  input  logic              ret_req,
  input  logic              ie_bit,
  input  logic [DATA_W-1:0] core_pc_next,
  input  logic [DATA_W-1:0] core_status,
  output seq_state_e        state,
  output logic              start_entry,
  output logic              start_ret,
  output logic              busy,
  output logic [DATA_W-1:0] saved_pc,
  output logic [DATA_W-1:0] saved_st
);
  seq_state_e state_q, state_d;
  logic idle;

  assign idle        = (state_q == S_IDLE);
  assign start_ret   = idle && insn_boundary && ret_req;
  assign start_entry = idle && insn_boundary && irq_req && ie_bit && !ret_req;
  assign busy        = !idle;
  assign state       = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_ret)        state_d = S_POP_ST;
        else if (start_entry) state_d = S_PUSH_PC;
      end
      S_PUSH_PC: state_d = S_PUSH_ST;
      S_PUSH_ST: state_d = S_IDLE;
      S_POP_ST:  state_d = S_POP_PC;
      S_POP_PC:  state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      saved_pc <= '0;
      saved_st <= '0;
    end else begin
      state_q <= state_d;
      if (start_entry) begin
        saved_pc <= core_pc_next;
        saved_st <= core_status;
      end
    end
  end

  assert_push_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PUSH_ST) |-> ($past(state_q) == S_PUSH_PC));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> !(state_q == S_PUSH_PC || state_q == S_POP_ST));
endmodule

// File: rtl/irq_seq_sp.sv
module irq_seq_sp #(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] STACK_TOP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] push_addr
);
  function automatic logic [ADDR_W-1:0] sp_below(input logic [ADDR_W-1:0] p);
    return p - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] sp_above(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  assign push_addr = sp_below(sp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp <= STACK_TOP;
    else if (push) sp <= sp_below(sp);
    else if (pop)  sp <= sp_above(sp);
  end
endmodule

// File: rtl/irq_seq_vecreg.sv
module irq_seq_vecreg #(
  parameter int               DATA_W     = 32,
  parameter logic [DATA_W-1:0] HVEC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] hvec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hvec <= HVEC_RESET;
    else if (we) hvec <= wdata;
  end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int               DATA_W     = 32,
  parameter int               ADDR_W     = 16,
  parameter int               IE_BIT     = 3,
  parameter logic [ADDR_W-1:0] STACK_TOP  = '1,
  parameter logic [DATA_W-1:0] HVEC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_boundary,
  input  logic              irq_req,
  input  logic              ret_req,
  input  logic [DATA_W-1:0] core_pc_next,
  input  logic [DATA_W-1:0] core_status,
  input  logic              hvec_we,
  input  logic [DATA_W-1:0] hvec_wdata,
  output logic              stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pc_load,
  output logic [DATA_W-1:0] pc_load_val,
  output logic              status_load,
  output logic [DATA_W-1:0] status_load_val
);
  localparam logic [DATA_W-1:0] IE_MASK = DATA_W'(1) << IE_BIT;

  seq_state_e        state;
  logic              start_entry, start_ret, busy;
  logic [DATA_W-1:0] saved_pc, saved_st, hvec;
  logic [ADDR_W-1:0] sp, push_addr;
  logic              in_push, in_pop;

  irq_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
    .irq_req(irq_req), .ret_req(ret_req), .ie_bit(core_status[IE_BIT]),
    .core_pc_next(core_pc_next), .core_status(core_status),
    .state(state), .start_entry(start_entry), .start_ret(start_ret),
    .busy(busy), .saved_pc(saved_pc), .saved_st(saved_st)
  );

  assign in_push = (state == S_PUSH_PC) || (state == S_PUSH_ST);
  assign in_pop  = (state == S_POP_ST)  || (state == S_POP_PC);

  irq_seq_sp #(.ADDR_W(ADDR_W), .STACK_TOP(STACK_TOP)) u_sp (
    .clk(clk), .rst_n(rst_n), .push(in_push), .pop(in_pop),
    .sp(sp), .push_addr(push_addr)
  );

  irq_seq_vecreg #(.DATA_W(DATA_W), .HVEC_RESET(HVEC_RESET)) u_vec (
    .clk(clk), .rst_n(rst_n), .we(hvec_we), .wdata(hvec_wdata), .hvec(hvec)
  );

  assign stall = busy || start_entry || start_ret;

  always_comb begin
    mem_req         = in_push || in_pop;
    mem_we          = in_push;
    mem_addr        = in_push ? push_addr : sp;
    mem_wdata       = (state == S_PUSH_ST) ? saved_st : saved_pc;
    pc_load         = 1'b0;
    pc_load_val     = hvec;
    status_load     = 1'b0;
    status_load_val = saved_st & ~IE_MASK;
    unique case (state)
      S_PUSH_ST: begin
        pc_load     = 1'b1;
        status_load = 1'b1;
      end
      S_POP_ST: begin
        status_load     = 1'b1;
        status_load_val = mem_rdata;
      end
      S_POP_PC: begin
        pc_load     = 1'b1;
        pc_load_val = mem_rdata;
      end
      default: ;
    endcase
  end

  assert_entry_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PUSH_PC) |-> $past(irq_req && insn_boundary && core_status[IE_BIT]));

  assert_ie_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && mem_we) |-> (status_load && !status_load_val[IE_BIT]));

  assert_mem_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> stall);

  assert_pop_climb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POP_PC) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

// File: tb/irq_stack_seq_tb.sv
`timescale 1ns/100ps
module irq_stack_seq_tb;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int IE_BIT = 3;
  localparam logic [ADDR_W-1:0] TOP  = 8'hF0;
  localparam logic [DATA_W-1:0] HRST = 32'h0000_0200;
  localparam logic [DATA_W-1:0] IE_M = 32'h8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic insn_boundary = 0, irq_req = 0, ret_req = 0, hvec_we = 0;
  logic [DATA_W-1:0] core_pc_next = '0, core_status = '0, hvec_wdata = '0;
  logic stall, mem_req, mem_we, pc_load, status_load;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata, pc_load_val, status_load_val;
  logic [DATA_W-1:0] tbmem [256];

  always #2.5 clk = ~clk;

  irq_stack_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IE_BIT(IE_BIT),
                  .STACK_TOP(TOP), .HVEC_RESET(HRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .irq_req(irq_req),
    .ret_req(ret_req), .core_pc_next(core_pc_next), .core_status(core_status),
    .hvec_we(hvec_we), .hvec_wdata(hvec_wdata), .stall(stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_load(pc_load),
    .pc_load_val(pc_load_val), .status_load(status_load),
    .status_load_val(status_load_val)
  );

  always @(posedge clk) if (mem_req && mem_we) tbmem[mem_addr] <= mem_wdata;
  assign mem_rdata = tbmem[mem_addr];

  int checks = 0, errors = 0;
  bit done = 0;

  // scoreboard: kind 0 write, 1 read, 2 pc load, 3 status load
  typedef struct { int kind; logic [31:0] addr; logic [31:0] data; string req; } ev_t;
  ev_t q[$];
  int sp_m = int'(TOP);
  logic [DATA_W-1:0] stk [256];
  logic [DATA_W-1:0] hvec_m = HRST;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void expect_ev(int k, logic [31:0] a, logic [31:0] d, string r);
    ev_t e;
    e.kind = k; e.addr = a; e.data = d; e.req = r;
    q.push_back(e);
  endfunction

  task automatic see(int k, logic [31:0] a, logic [31:0] d);
    ev_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R1/R8 unexpected event: actual kind %0d addr %h data %h expected none", k, a, d);
    end else begin
      e = q.pop_front();
      if (e.kind != k || e.addr !== a || e.data !== d) begin
        errors++;
        $display("FAIL %s: actual kind %0d addr %h data %h expected kind %0d addr %h data %h",
                 e.req, k, a, d, e.kind, e.addr, e.data);
      end
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (mem_req) see(mem_we ? 0 : 1, 32'(mem_addr), mem_we ? mem_wdata : 32'h0);
    if (status_load) see(3, 32'h0, status_load_val);
    if (pc_load) see(2, 32'h0, pc_load_val);
  end

  task automatic clear_req();
    irq_req = 0; ret_req = 0; insn_boundary = 0;
  endtask

  // accepting cycle plus two sequence cycles, stall checked in each (R5)
  task automatic run_steps(bit hold, string r);
    @(negedge clk); chk({r, " R5 accept stall"}, 32'(stall), 32'h1);
    @(posedge clk); #1;
    if (hold) begin irq_req = 1; ret_req = 1; insn_boundary = 1; end
    else clear_req();
    @(negedge clk); chk({r, " R5 step1 stall"}, 32'(stall), 32'h1);
    @(posedge clk); #1;
    @(negedge clk); chk({r, " R5 step2 stall"}, 32'(stall), 32'h1);
    @(posedge clk); #1; clear_req();
    @(negedge clk); chk({r, " R5 released"}, 32'(stall), 32'h0);
    @(posedge clk); #1;
  endtask

  task automatic do_entry(logic [31:0] pc, logic [31:0] st, bit hold);
    stk[sp_m-1] = pc; stk[sp_m-2] = st;
    expect_ev(0, 32'(sp_m-1), pc, "R2");
    expect_ev(0, 32'(sp_m-2), st, "R3");
    expect_ev(3, 32'h0, st & ~IE_M, "R4");
    expect_ev(2, 32'h0, hvec_m, "R4/R6");
    sp_m -= 2;
    core_pc_next = pc; core_status = st; irq_req = 1; insn_boundary = 1;
    run_steps(hold, "entry");
  endtask

  task automatic do_return(bit hold, bit with_irq, string r);
    expect_ev(1, 32'(sp_m), 32'h0, r);
    expect_ev(3, 32'h0, stk[sp_m], r);
    expect_ev(1, 32'(sp_m+1), 32'h0, r);
    expect_ev(2, 32'h0, stk[sp_m+1], r);
    sp_m += 2;
    core_status = IE_M; ret_req = 1; insn_boundary = 1; irq_req = with_irq;
    run_steps(hold, "return");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10 stall", 32'(stall), 32'h0);
    chk("R10 mem_req", 32'(mem_req), 32'h0);
    chk("R10 pc_load", 32'(pc_load), 32'h0);
    chk("R10 status_load", 32'(status_load), 32'h0);
    // R1: enable bit clear, then boundary low
    @(posedge clk); #1 irq_req = 1; insn_boundary = 1; core_status = 32'hF7;
    @(negedge clk); chk("R1 ie clear no stall", 32'(stall), 32'h0);
    @(posedge clk); #1 insn_boundary = 0; core_status = 32'hFF;
    @(negedge clk); chk("R1 no boundary no stall", 32'(stall), 32'h0);
    @(posedge clk); #1 clear_req();
    // first entry with reset handler value (R6, R10 first push at TOP-1)
    do_entry(32'h0000_1000, 32'h0000_00A8, 0);
    @(posedge clk); #1 hvec_we = 1; hvec_wdata = 32'h0000_4000;
    @(posedge clk); #1 hvec_we = 0; hvec_m = 32'h0000_4000;
    // nested entry while requests held high during the sequence (R8)
    do_entry(32'h0000_2004, 32'h0000_000F, 1);
    do_return(1, 0, "R7/R8");
    do_return(0, 0, "R7");
    // R9: both requests, return wins
    do_entry(32'h0000_3000, 32'h0000_0008, 0);
    do_return(0, 1, "R9");
    // R10/R7: stack pointer back at top, push lands at TOP-1 again
    do_entry(32'h0000_5550, 32'h0000_0019, 0);
    do_return(0, 0, "R7");
    repeat (2) @(posedge clk);
    chk("R8 scoreboard drained", 32'(q.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule